// File: doc/BRIEF.md
# Cache Tag Directory with Compare

This block is the directory memory of a cache. Each cache line owns one tag word with a valid flag, plus a small coherence-status word held in a second array. Both arrays are addressed by the same line index. The tag array can be read and written like a plain memory. It also has a compare mode. In that mode the stored tag is fetched internally, it is not driven on the read port, and it is checked against the address tag presented on the tag input. A match output then reports a hit.

The valid flags are kept in a flip-flop vector. An active-low clear input wipes all of them at once, so every lookup after initialisation misses. The status array has its own write enable and its own read port, so a controller can update coherence state without touching the tag. It can also combine the match result with the status to decide how to answer a processor access or a snoop. All writes take effect on the rising clock edge. Reads and compares are combinational. Two chip selects of opposite polarity gate the whole device.

Top module: `tag_dir`

## Requirements
- R1: The depth and widths are set by the parameters LINES (default 1024), TAG_W (default 12) and ST_W (default 3). The line index selects one entry in each array, and every entry in the range 0 to LINES-1 holds its own tag, valid flag and status.
- R2: While the device is selected and tag_we is 1 at a rising clock edge, tag_in and valid_in are stored at line_idx.
- R3: While the device is selected and tag_cmp is 0, tag_out and valid_out show the stored entry at line_idx combinationally. Otherwise both are 0, and in compare mode the stored tag never appears on tag_out.
- R4: match is 1 exactly when the device is selected, tag_cmp is 1, the stored valid flag is 1 and the stored tag equals tag_in. In every other case it is 0.
- R5: While vclr_n is 0, all valid flags are 0 at once. A tag write in the same cycle still stores its tag but leaves valid at 0. Stored tags and status words are kept.
- R6: While the device is selected and st_we is 1 at a rising edge, st_in is stored at line_idx. While selected, st_out shows the stored status combinationally, and it is 0 otherwise. A status write leaves the tag entry unchanged.
- R7: The device is selected only when cs_hi is 1 and cs_lo_n is 0. While it is not selected, no write takes effect and tag_out, valid_out, st_out and match are all 0.
- R8: When a write and a compare hit the same line in one cycle, match reflects the contents from before the write.
- R9: After a miss, a single tag write with valid_in set to 1 makes the next compare of that tag at that line report a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| vclr_n | input | 1 | Active-low flash clear of all valid flags |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_n | input | 1 | Active-low chip select |
| line_idx | input | IDX_W | Line index shared by both arrays |
| tag_we | input | 1 | Tag write enable |
| tag_cmp | input | 1 | Compare mode select |
| tag_in | input | TAG_W | Tag write data and compare tag |
| valid_in | input | 1 | Valid flag written with the tag |
| tag_out | output | TAG_W | Stored tag (read mode only) |
| valid_out | output | 1 | Stored valid flag (read mode only) |
| match | output | 1 | Hit indication in compare mode |
| st_we | input | 1 | Status write enable |
| st_in | input | ST_W | Status write data |
| st_out | output | ST_W | Stored status |

## Verification
tag_out, valid_out, match and st_out are combinational, so they are due in the same cycle as the index and mode that select them. The bench drives on the falling edge and samples 2 ns later, before the next rising edge. A write is visible from the cycle after its rising edge. The bench updates its reference arrays just after that edge, and the first check that can see the write is made in the following cycle. The flash clear is asynchronous, so its effect is checked in the same low phase in which it is applied.

// File: rtl/tag_dir.sv
module tag_dir #(
  parameter int LINES = 1024,
  parameter int TAG_W = 12,
  parameter int ST_W  = 3,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             vclr_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic [IDX_W-1:0] line_idx,
  input  logic             tag_we,
  input  logic             tag_cmp,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             valid_in,
  output logic [TAG_W-1:0] tag_out,
  output logic             valid_out,
  output logic             match,
  input  logic             st_we,
  input  logic [ST_W-1:0]  st_in,
  output logic [ST_W-1:0]  st_out
);

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [ST_W-1:0]  st_mem  [LINES];
  logic [LINES-1:0] vld;

  logic             sel;
  logic [TAG_W-1:0] tag_rd;
  logic             vld_rd;

  assign sel    = cs_hi & ~cs_lo_n;
  assign tag_rd = tag_mem[line_idx];
  assign vld_rd = vld[line_idx];

  always_ff @(posedge clk)
    if (sel && tag_we) tag_mem[line_idx] <= tag_in;

  always_ff @(posedge clk)
    if (sel && st_we) st_mem[line_idx] <= st_in;

  // flash clear wins over any same-cycle write of a valid flag
  always_ff @(posedge clk or negedge vclr_n)
    if (!vclr_n)             vld <= '0;
    else if (sel && tag_we)  vld[line_idx] <= valid_in;

  assign tag_out   = (sel && !tag_cmp) ? tag_rd : '0;
  assign valid_out = sel && !tag_cmp && vld_rd;
  assign match     = sel && tag_cmp && vld_rd && (tag_rd == tag_in);
  assign st_out    = sel ? st_mem[line_idx] : '0;

endmodule

// File: rtl/tag_dir_chk.sv
module tag_dir_chk #(
  parameter int LINES = 1024,
  parameter int TAG_W = 12,
  parameter int ST_W  = 3,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             vclr_n,
  input logic             cs_hi,
  input logic             cs_lo_n,
  input logic [IDX_W-1:0] line_idx,
  input logic             tag_we,
  input logic             tag_cmp,
  input logic [TAG_W-1:0] tag_in,
  input logic             valid_in,
  input logic [TAG_W-1:0] tag_out,
  input logic             valid_out,
  input logic             match,
  input logic             st_we,
  input logic [ST_W-1:0]  st_in,
  input logic [ST_W-1:0]  st_out
);

  logic on;
  assign on = cs_hi && !cs_lo_n;

  assert_match_gated_R4: assert property (@(posedge clk) disable iff (!vclr_n)
    match |-> (on && tag_cmp));

  assert_read_hidden_R3: assert property (@(posedge clk) disable iff (!vclr_n)
    (!on || tag_cmp) |-> (tag_out == '0 && !valid_out));

  assert_idle_status_R7: assert property (@(posedge clk) disable iff (!vclr_n)
    !on |-> (st_out == '0 && !match));

  assert_fill_hit_R9: assert property (@(posedge clk) disable iff (!vclr_n)
    (on && tag_we && valid_in) ##1 (on && tag_cmp && $stable(line_idx) && $stable(tag_in))
      |-> match);

  assert_status_store_R6: assert property (@(posedge clk) disable iff (!vclr_n)
    (on && st_we) ##1 (on && $stable(line_idx)) |-> (st_out == $past(st_in)));

endmodule

bind tag_dir tag_dir_chk #(.LINES(LINES), .TAG_W(TAG_W), .ST_W(ST_W)) u_chk (.*);

// File: tb/tag_dir_tb.sv
module tag_dir_tb;
  localparam int LINES = 1024;
  localparam int TAG_W = 12;
  localparam int ST_W  = 3;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 0;
  logic vclr_n, cs_hi, cs_lo_n, tag_we, tag_cmp, valid_in, st_we;
  logic [IDX_W-1:0] line_idx;
  logic [TAG_W-1:0] tag_in, tag_out;
  logic [ST_W-1:0]  st_in, st_out;
  logic valid_out, match;

  tag_dir #(.LINES(LINES), .TAG_W(TAG_W), .ST_W(ST_W)) u_dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [TAG_W-1:0] m_tag [LINES];
  logic [ST_W-1:0]  m_st  [LINES];
  bit m_vld [LINES];
  bit m_tk  [LINES];
  bit m_sk  [LINES];

  function automatic bit is_sel();
    return cs_hi && !cs_lo_n;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < LINES; i++) m_vld[i] = 0;
  endtask

  task automatic auto_checks();
    bit s = is_sel();
    bit rd = s && !tag_cmp;
    bit e_m = s && tag_cmp && m_vld[line_idx] && (m_tag[line_idx] == tag_in);
    if (!rd || m_tk[line_idx])
      chk(tag_out === (rd ? m_tag[line_idx] : '0), "R3 tag_out", tag_out, rd ? m_tag[line_idx] : 0);
    chk(valid_out === (rd && m_vld[line_idx]), "R3 valid_out", valid_out, rd && m_vld[line_idx]);
    chk(match === e_m, "R4 match", match, e_m);
    if (!s || m_sk[line_idx])
      chk(st_out === (s ? m_st[line_idx] : '0), "R6 st_out", st_out, s ? m_st[line_idx] : 0);
  endtask

  // drive at negedge, check, cross the edge, update reference, return at negedge
  task automatic cyc();
    if (!vclr_n) clear_model();
    #2 auto_checks();
    @(posedge clk);
    if (is_sel() && tag_we) begin
      m_tag[line_idx] = tag_in; m_tk[line_idx] = 1;
      if (vclr_n) m_vld[line_idx] = valid_in;
    end
    if (is_sel() && st_we) begin
      m_st[line_idx] = st_in; m_sk[line_idx] = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle_sel();
    vclr_n = 1; cs_hi = 1; cs_lo_n = 0; tag_we = 0; tag_cmp = 0; st_we = 0; valid_in = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < LINES; i++) begin m_vld[i] = 0; m_tk[i] = 0; m_sk[i] = 0; end
    idle_sel(); vclr_n = 0; line_idx = 5; tag_in = 12'habc; st_in = 0; tag_cmp = 1;
    @(negedge clk);
    #2; chk(match === 0, "R5 reset miss", match, 0);
    cyc(); cyc();
    vclr_n = 1;
    cyc();
    chk(match === 0, "R9 miss before fill", match, 0);
    // fill after miss
    tag_cmp = 0; tag_we = 1; valid_in = 1; cyc();
    tag_we = 0; tag_cmp = 1; #2;
    chk(match === 1, "R9 hit after fill", match, 1);
    chk(tag_out === 0, "R3 tag hidden in compare", tag_out, 0);
    cyc();
    tag_in = 12'habd; #2; chk(match === 0, "R4 mismatch", match, 0); cyc();
    // chip-select truth table
    tag_in = 12'habc;
    for (int c = 0; c < 4; c++) begin
      cs_hi = c[1]; cs_lo_n = c[0]; #2;
      chk(match === (c == 2), "R7 select table", match, c == 2);
      cyc();
    end
    // unselected write ignored
    cs_hi = 0; cs_lo_n = 0; tag_cmp = 0; tag_we = 1; tag_in = 12'h111; st_we = 1; st_in = 3'd6; cyc();
    idle_sel(); #2;
    chk(tag_out === 12'habc, "R7 unselected write ignored", tag_out, 12'habc);
    cyc();
    // status write does not disturb tag
    st_we = 1; st_in = 3'd5; cyc();
    st_we = 0; #2;
    chk(st_out === 3'd5, "R6 status stored", st_out, 5);
    chk(tag_out === 12'habc && valid_out === 1, "R6 tag untouched", tag_out, 12'habc);
    cyc();
    // same-cycle write and compare
    tag_cmp = 1; tag_we = 1; valid_in = 1; tag_in = 12'h222; #2;
    chk(match === 0, "R8 compare sees old contents", match, 0);
    cyc();
    tag_we = 0; #2; chk(match === 1, "R8 new tag after write", match, 1); cyc();
    // flash clear keeps payload, overrides same-cycle write
    tag_cmp = 0; vclr_n = 0; #1;
    chk(valid_out === 0, "R5 valid cleared", valid_out, 0);
    chk(tag_out === 12'h222, "R5 tag kept", tag_out, 12'h222);
    chk(st_out === 3'd5, "R5 status kept", st_out, 5);
    line_idx = 9; tag_we = 1; valid_in = 1; tag_in = 12'h333; cyc();
    idle_sel(); #2;
    chk(valid_out === 0 && tag_out === 12'h333, "R5 clear beats write", valid_out, 0);
    cyc();
    // boundary indices
    line_idx = '0; tag_we = 1; valid_in = 1; tag_in = 12'h0f0; cyc();
    line_idx = IDX_W'(LINES - 1); tag_in = 12'hf0f; cyc();
    tag_we = 0; line_idx = '0; #2;
    chk(tag_out === 12'h0f0, "R1 first line", tag_out, 12'h0f0); cyc();
    line_idx = IDX_W'(LINES - 1); #2;
    chk(tag_out === 12'hf0f, "R1 last line", tag_out, 12'hf0f);
    chk(valid_out === 1, "R2 valid stored", valid_out, 1); cyc();
    // random mix over a few lines and tags
    for (int n = 0; n < 4000; n++) begin
      vclr_n   = ($urandom % 64) != 0;
      cs_hi    = ($urandom % 8) != 0;
      cs_lo_n  = ($urandom % 8) == 0;
      line_idx = IDX_W'($urandom % 16);
      tag_we   = ($urandom % 3) == 0;
      tag_cmp  = ($urandom % 2) == 0;
      tag_in   = TAG_W'($urandom % 4);
      valid_in = ($urandom % 4) != 0;
      st_we    = ($urandom % 3) == 0;
      st_in    = ST_W'($urandom);
      cyc();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule